// File: doc/BRIEF.md
# Lockable Chip-Select Configuration Register Bank

This block holds one configuration byte for each of four external memory chip selects, plus a lock register. A host reaches it through a plain register bus: byte address, 32-bit write data, a write strobe, a read strobe, and registered read data. Each configuration byte is split into fields that go straight to a memory access engine. These fields are a wait count, a synchronous/asynchronous flag, a write-permission flag and a data-width code.

Configuration can only change after a 16-bit key has been written to the lock register. Writing anything else to the lock register closes the bank again, and that includes zero. After reset the bank is closed. The boot ROM and flash selects come up with writes forbidden, so firmware must open the bank and set the write-permission bit before it can program flash.

The chip selects are numbered 0 to 3: 0 is boot ROM, 1 is flash, 2 is synchronous SRAM and 3 is expansion memory.

Top module: `cfg_lock_bank`

## Requirements
- R1: After reset the bank is locked and the configuration bytes are 0xF2 for chip selects 0 and 1, 0x0E for chip select 2 and 0x06 for chip select 3. The flash select (chip select 1) therefore has write permission cleared.
- R2: A read of offset 0x20 returns 1 in bit 0 while locked and 0 while unlocked, with every other bit zero.
- R3: Writing exactly 0x0000A05F to offset 0x20 unlocks the bank. The lock read value becomes 0 from the next read onward.
- R4: Writing any other value to offset 0x20 locks the bank, or keeps it locked. This covers zero, 0x1234 and 0xFFFFA05F.
- R5: While the bank is locked, writes to the configuration offsets leave every configuration byte and every output field unchanged.
- R6: While the bank is unlocked, a write to offset 4*n (n = 0..3) stores wdata[7:0] as byte n. The byte's fields appear on the outputs in the cycle after the write strobe: wait count from bits [7:4], sync from bit 3 (1 = synchronous), write permission from bit 2 (1 = allowed) and width from bits [1:0] (00 = 8-bit, 01 = 16-bit, 10 = 32-bit).
- R7: Configuration bytes can be read whatever the lock state. Read data appears in the cycle after the read strobe, and bits [31:8] are always zero. Read data is zero in any cycle that follows no read strobe.
- R8: If a read and a write to the same offset fall in the same cycle, the read returns the value held before that write.
- R9: Writes to offsets that are not mapped change no state, and reads of such offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Registered read data, valid the cycle after bus_rd |
| cs_wait | output | 16 | Wait count, 4 bits per chip select, select n at [4n+3:4n] |
| cs_sync | output | 4 | Synchronous-mode flag per chip select |
| cs_wr_en | output | 4 | Write-permission flag per chip select |
| cs_width | output | 8 | Data-width code, 2 bits per chip select, select n at [2n+1:2n] |

## Verification
Reading and writing can land in the same cycle, and so can reading the lock state and changing it. The bench raises both strobes together on a configuration offset, and again on the lock offset while it writes zero. It expects the read to return the value held before the write. A second read in a later cycle then has to show the new value. Both results are judged by the scoreboard against a model kept in the bench.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;

  typedef struct packed {
    logic [3:0] wait_cnt;
    logic       sync;
    logic       wr_ok;
    logic [1:0] width;
  } cs_cfg_t;

  localparam logic [15:0] UNLOCK_KEY = 16'hA05F;

  localparam logic [1:0] WIDTH_8  = 2'b00;
  localparam logic [1:0] WIDTH_16 = 2'b01;
  localparam logic [1:0] WIDTH_32 = 2'b10;

  function automatic cs_cfg_t reset_cfg(input int idx);
    cs_cfg_t c;
    case (idx)
      0, 1:    c = '{wait_cnt: 4'hF, sync: 1'b0, wr_ok: 1'b0, width: WIDTH_32};
      2:       c = '{wait_cnt: 4'h0, sync: 1'b1, wr_ok: 1'b1, width: WIDTH_32};
      default: c = '{wait_cnt: 4'h0, sync: 1'b0, wr_ok: 1'b1, width: WIDTH_32};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/cfg_lock_ctrl.sv
module cfg_lock_ctrl #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_i,
  input  logic          hit_i,
  input  logic [DW-1:0] wdata_i,
  output logic          locked_o
);
  import cfg_bank_pkg::*;

  localparam logic [DW-1:0] KEY_W = {{(DW-16){1'b0}}, UNLOCK_KEY};

  logic locked_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      locked_q <= 1'b1;
    end else if (wr_i && hit_i) begin
      locked_q <= (wdata_i != KEY_W);
    end
  end

  assign locked_o = locked_q;

  a_r1_locked_after_reset: assert property (@(posedge clk)
    $past(rst) |-> locked_q);

  a_r3_key_opens: assert property (@(posedge clk) disable iff (rst)
    (wr_i && hit_i && wdata_i == KEY_W) |=> !locked_q);

  a_r4_other_closes: assert property (@(posedge clk) disable iff (rst)
    (wr_i && hit_i && wdata_i != KEY_W) |=> locked_q);

  a_r4_no_write_holds: assert property (@(posedge clk) disable iff (rst)
    !(wr_i && hit_i) |=> $stable(locked_q));

endmodule

// File: rtl/cfg_slot.sv
module cfg_slot #(
  parameter int IDX = 0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_i,
  input  logic                   sel_i,
  input  logic                   locked_i,
  input  logic [7:0]             wdata_i,
  output cfg_bank_pkg::cs_cfg_t  cfg_o
);
  import cfg_bank_pkg::*;

  localparam cs_cfg_t RST_VAL = reset_cfg(IDX);

  cs_cfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= RST_VAL;
    end else if (wr_i && sel_i && !locked_i) begin
      cfg_q <= cs_cfg_t'(wdata_i);
    end
  end

  assign cfg_o = cfg_q;

  a_r5_locked_hold: assert property (@(posedge clk) disable iff (rst)
    locked_i |=> $stable(cfg_q));

  a_r6_write_taken: assert property (@(posedge clk) disable iff (rst)
    (wr_i && sel_i && !locked_i) |=> (cfg_q == cs_cfg_t'($past(wdata_i))));

  a_r9_unselected_hold: assert property (@(posedge clk) disable iff (rst)
    !(wr_i && sel_i) |=> $stable(cfg_q));

endmodule

// File: rtl/cfg_read_port.sv
module cfg_read_port #(
  parameter int NCS = 4,
  parameter int DW  = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_i,
  input  logic [NCS-1:0]       cs_sel_i,
  input  logic                 lock_sel_i,
  input  logic [NCS-1:0][7:0]  cfg_i,
  input  logic                 locked_i,
  output logic [DW-1:0]        rdata_o
);
  logic [DW-1:0] rd_mux;
  logic [DW-1:0] rdata_q;

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NCS; i++) begin
      if (cs_sel_i[i]) rd_mux[7:0] = cfg_i[i];
    end
    if (lock_sel_i) rd_mux[0] = locked_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_i) begin
      rdata_q <= rd_mux;
    end else begin
      rdata_q <= '0;
    end
  end

  assign rdata_o = rdata_q;

  a_r7_upper_zero: assert property (@(posedge clk) disable iff (rst)
    rdata_q[DW-1:8] == '0);

  a_r7_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> rdata_q == '0);

  a_r2_lock_readback: assert property (@(posedge clk) disable iff (rst)
    (rd_i && lock_sel_i) |=> (rdata_q[0] == $past(locked_i) && rdata_q[7:1] == '0));

endmodule

// File: rtl/cfg_lock_bank.sv
module cfg_lock_bank #(
  parameter int                NCS      = 4,
  parameter int                AW       = 8,
  parameter int                DW       = 32,
  parameter logic [AW-1:0]     LOCK_OFS = 8'h20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DW-1:0]     bus_rdata,
  output logic [NCS*4-1:0]  cs_wait,
  output logic [NCS-1:0]    cs_sync,
  output logic [NCS-1:0]    cs_wr_en,
  output logic [NCS*2-1:0]  cs_width
);
  import cfg_bank_pkg::*;

  localparam int STRIDE = 4;

  logic [NCS-1:0]      cs_sel;
  logic                lock_sel;
  logic                locked;
  cs_cfg_t             slot_cfg [NCS];
  logic [NCS-1:0][7:0] cfg_bytes;

  assign lock_sel = (bus_addr == LOCK_OFS);

  cfg_lock_ctrl #(.DW(DW)) u_lock (
    .clk      (clk),
    .rst      (rst),
    .wr_i     (bus_wr),
    .hit_i    (lock_sel),
    .wdata_i  (bus_wdata),
    .locked_o (locked)
  );

  for (genvar g = 0; g < NCS; g++) begin : g_slot
    assign cs_sel[g] = (bus_addr == AW'(g * STRIDE));

    cfg_slot #(.IDX(g)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .wr_i     (bus_wr),
      .sel_i    (cs_sel[g]),
      .locked_i (locked),
      .wdata_i  (bus_wdata[7:0]),
      .cfg_o    (slot_cfg[g])
    );

    assign cfg_bytes[g]       = slot_cfg[g];
    assign cs_wait[g*4 +: 4]  = slot_cfg[g].wait_cnt;
    assign cs_sync[g]         = slot_cfg[g].sync;
    assign cs_wr_en[g]        = slot_cfg[g].wr_ok;
    assign cs_width[g*2 +: 2] = slot_cfg[g].width;
  end

  cfg_read_port #(.NCS(NCS), .DW(DW)) u_rd (
    .clk        (clk),
    .rst        (rst),
    .rd_i       (bus_rd),
    .cs_sel_i   (cs_sel),
    .lock_sel_i (lock_sel),
    .cfg_i      (cfg_bytes),
    .locked_i   (locked),
    .rdata_o    (bus_rdata)
  );

  a_r3_sel_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cs_sel, lock_sel}));

endmodule

// File: tb/sim_cfg_lock_bank.sv
module sim_cfg_lock_bank;
  localparam int NCS = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [15:0] cs_wait;
  logic [3:0]  cs_sync;
  logic [3:0]  cs_wr_en;
  logic [7:0]  cs_width;

  int n_run = 0;
  int n_fail = 0;
  logic done = 1'b0;

  logic [7:0]  exp_cfg [NCS];
  logic        exp_locked;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #2.5 clk = ~clk;

  cfg_lock_bank u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .cs_wait(cs_wait), .cs_sync(cs_sync), .cs_wr_en(cs_wr_en), .cs_width(cs_width)
  );

  function automatic logic [31:0] model_read(input logic [7:0] a);
    if (a == 8'h20) return {31'b0, exp_locked};
    if (a[1:0] == 2'b00 && a < 8'h10) return {24'b0, exp_cfg[a[3:2]]};
    return 32'h0;
  endfunction

  function automatic void model_write(input logic [7:0] a, input logic [31:0] d);
    if (a == 8'h20) exp_locked = (d != 32'h0000A05F);
    else if (a[1:0] == 2'b00 && a < 8'h10 && !exp_locked) exp_cfg[a[3:2]] = d[7:0];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_outputs(input string tag);
    for (int i = 0; i < NCS; i++) begin
      check($sformatf("%s cs%0d fields", tag, i),
            {cs_wait[i*4 +: 4], cs_sync[i], cs_wr_en[i], cs_width[i*2 +: 2]},
            {24'b0, exp_cfg[i]});
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
    model_write(a, d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0;
    exp_q.push_back(model_read(a));
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic bus_rw(input logic [7:0] a, input logic [31:0] d, input string tag);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_rd = 1'b1; bus_wr = 1'b1;
    exp_q.push_back(model_read(a));
    tag_q.push_back(tag);
    model_write(a, d);
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
  endtask

  // Scoreboard monitor: compares read data one cycle after each strobe
  always @(posedge clk) begin
    logic was_rd;
    logic [31:0] e;
    string t;
    was_rd = bus_rd && !rst;
    #1;
    if (was_rd) begin
      if (exp_q.size() == 0) begin
        check("scoreboard underflow", bus_rdata, 32'h0);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, bus_rdata, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    exp_cfg[0] = 8'hF2; exp_cfg[1] = 8'hF2; exp_cfg[2] = 8'h0E; exp_cfg[3] = 8'h06;
    exp_locked = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    check_outputs("R1 reset");
    check("R1 flash write disabled", {31'b0, cs_wr_en[1]}, 32'h0);
    bus_read(8'h20, "R1 R2 locked after reset");

    bus_write(8'h04, 32'h0000_0037);
    check_outputs("R5 locked write cs1");
    bus_read(8'h04, "R7 R5 read cs1 while locked");
    bus_write(8'h00, 32'h0000_0000);
    check_outputs("R5 locked write cs0");

    bus_write(8'h20, 32'h0000_1234);
    bus_read(8'h20, "R4 wrong key stays locked");
    bus_write(8'h20, 32'hFFFF_A05F);
    bus_read(8'h20, "R4 key with upper bits stays locked");
    bus_write(8'h08, 32'h0000_0055);
    check_outputs("R4 R5 still locked");

    bus_write(8'h20, 32'h0000_A05F);
    bus_read(8'h20, "R3 R2 unlocked reads zero");
    bus_write(8'h04, 32'h0000_00F6);
    check_outputs("R6 cs1 write enable");
    bus_write(8'h08, 32'h0000_0059);
    check_outputs("R6 cs2 wait5 sync 16bit");
    bus_write(8'h00, 32'h0000_0030);
    check_outputs("R6 cs0 8bit");
    bus_write(8'h0C, 32'hFFFF_FF3C);
    bus_read(8'h0C, "R7 upper bits zero on cs3");

    bus_write(8'h10, 32'hFFFF_FFFF);
    check_outputs("R9 unmapped write");
    bus_write(8'h02, 32'hFFFF_FFFF);
    check_outputs("R9 misaligned write");
    bus_read(8'h10, "R9 unmapped read zero");
    bus_read(8'h20, "R9 still unlocked");

    bus_rw(8'h0C, 32'h0000_00A1, "R8 same-cycle read old cs3");
    bus_read(8'h0C, "R8 new cs3 after rw");
    check_outputs("R8 R6 outputs after rw");

    bus_rw(8'h20, 32'h0000_0000, "R8 same-cycle read old lock");
    bus_read(8'h20, "R4 zero relocks");
    bus_write(8'h04, 32'h0000_0000);
    check_outputs("R5 relocked write ignored");

    @(negedge clk);
    check("R7 idle read data zero", bus_rdata, 32'h0);

    repeat (3) @(negedge clk);
    check("scoreboard drained", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule